// File: doc/BRIEF.md
# Serial Command Frame Encoder

This block turns bus-master requests for a two-wire serial service bus into complete outgoing command frames. An access request carries a 2-bit target id, a 21-bit byte address, a transfer size, a direction flag and up to four bytes of write data. The block picks the shortest address form that reaches the target. The forms are a full address, a signed offset from the previous access, or a reuse of the previous word address. It then packs the fields, closes the frame with a 4-bit CRC and hands the frame out left-aligned in a 64-bit word, together with its length in bits. It can also build the fixed data-poll, error-poll and terminate frames.

The block remembers the address of the last access that completed. The link layer downstream drives a completion pulse with a success flag once each frame's transfer has ended. Only a successful access refreshes the stored address. A failed transfer, a completed terminate or a link break makes the stored address unusable. Serialising the frame onto the wire is left to the next block.

Top module: `svc_frame_encoder`

## Requirements
- R1: After reset `req_ready` is 1, `frame_valid` is 0 and the stored address is invalid, so the first access always uses the absolute form.
- R2: An access frame carries, from its first bit: id (2 bits), opcode, a direction bit (1 = read, 0 = write), the address field, a size bit, write data, then the CRC. The absolute form uses opcode 3'b100 and the full 21-bit address.
- R3: When the stored value equals {id, addr[20:2], 2'b00}, the same-address form is used: opcode 2'b11 and a 2-bit address field holding the low address bits.
- R4: Otherwise, when the stored value is valid with the same id and addr minus the stored 21-bit address lies in -256..+255, the relative form is used: opcode 3'b101 and a 9-bit two's-complement offset. An offset of +256 or -257 falls back to the absolute form.
- R5: A request to a different id than the stored one uses the absolute form.
- R6: `req_size` 0 means 1 byte (size bit 0, address unchanged). 1 means 2 bytes (address bit 0 cleared, size bit 1). 2 or 3 means 4 bytes (address bits [1:0] forced to 01, size bit 1). The address field is aligned this way in every form.
- R7: A write appends `req_size` bytes, `req_wdata[7:0]` first, each byte sent MSB first. A read appends no data.
- R8: The CRC is 4 bits, polynomial x^4+x^2+x+1, initial value 0, MSB first, computed over a leading 1 followed by every frame bit. The frame's first bit is at bit 63 of `frame_data`, `frame_len` counts all bits including the CRC, and all bits below the frame are 0.
- R9: `req_kind` 1 builds a data poll (id, 3'b010, CRC), 2 builds an error poll (id, 3'b011, CRC) and 3 builds a terminate (id, 6'b111111, CRC). `req_kind` 0 is an access.
- R10: A `xfer_done` pulse with `xfer_ok`=1 for an access stores {id, addr[20:2], 2'b00}. A pulse with `xfer_ok`=0, a completed terminate or `link_break` invalidates the stored value. A successful poll leaves it unchanged.
- R11: A request is accepted only while `req_ready` is 1, and `req_ready` stays low until the frame is taken. `frame_data` and `frame_len` hold steady while `frame_valid` is 1 and `frame_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 2 | 0 access, 1 data poll, 2 error poll, 3 terminate |
| req_id | input | 2 | Target id |
| req_addr | input | 21 | Byte address |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write bytes, byte 0 in bits [7:0] |
| frame_valid | output | 1 | Frame available |
| frame_ready | input | 1 | Downstream takes the frame |
| frame_data | output | 64 | Left-aligned frame |
| frame_len | output | 7 | Frame length in bits |
| xfer_done | input | 1 | Transfer of the last frame has ended |
| xfer_ok | input | 1 | Ended transfer succeeded |
| link_break | input | 1 | Link reset; invalidates the stored address |

## Verification
The assertions assume that `xfer_done` refers to the most recently accepted request and arrives after its frame has been taken. They also assume that `frame_ready` and the request fields behave like registered signals. The bench keeps to this by sending one request at a time. It waits for the frame to leave, then pulses `xfer_done` and only afterwards offers the next request. `link_break` is pulsed only between transfers. Address sequences are chosen around the stored word so that all three forms and the offset limits of R4 are reached, and `frame_ready` is throttled during part of the run.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int ID_W     = 2;
  localparam int ADDR_W   = 21;
  localparam int REL_W    = 9;
  localparam int CRC_W    = 4;
  localparam int FRAME_W  = 64;
  localparam int MSG_W    = FRAME_W - CRC_W;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int MLEN_W   = $clog2(MSG_W + 1);
  localparam int NBYTES   = 4;
  localparam int LAST_W   = ID_W + ADDR_W;
  localparam logic [LAST_W-1:0] LAST_INVALID = LAST_W'(1);

  localparam logic [2:0] OP_ABS   = 3'b100;
  localparam logic [2:0] OP_REL   = 3'b101;
  localparam logic [1:0] OP_SAME  = 2'b11;
  localparam logic [2:0] OP_DPOLL = 3'b010;
  localparam logic [2:0] OP_EPOLL = 3'b011;
  localparam logic [5:0] OP_TERM  = 6'b111111;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0111;

  typedef enum logic [1:0] {K_ACCESS = 2'd0, K_DPOLL = 2'd1, K_EPOLL = 2'd2, K_TERM = 2'd3} req_kind_e;
  typedef enum logic [1:0] {M_ABS = 2'd0, M_REL = 2'd1, M_SAME = 2'd2} addr_mode_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/frm_last_addr.sv
module frm_last_addr
  import frm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [1:0]        cap_kind,
  input  logic [ID_W-1:0]   cap_id,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              xfer_done,
  input  logic              xfer_ok,
  input  logic              link_break,
  output addr_mode_e        mode,
  output logic [REL_W-1:0]  rel_off
);
  logic [LAST_W-1:0] last_q, last_d;
  logic [1:0]        pkind_q, pkind_d;
  logic [ID_W-1:0]   pid_q, pid_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              plive_q, plive_d;
  logic signed [ADDR_W:0] diff;
  logic [LAST_W-1:0] word_key;

  // mode decision against the stored value
  always_comb begin
    word_key = {cap_id, cap_addr[ADDR_W-1:2], 2'b00};
    diff     = $signed({1'b0, cap_addr}) - $signed({1'b0, last_q[ADDR_W-1:0]});
    rel_off  = diff[REL_W-1:0];
    if (last_q == word_key)
      mode = M_SAME;
    else if (!last_q[0] && last_q[LAST_W-1:ADDR_W] == cap_id &&
             diff >= -(ADDR_W+1)'(256) && diff <= (ADDR_W+1)'(255))
      mode = M_REL;
    else
      mode = M_ABS;
  end

  always_comb begin
    last_d  = last_q;
    pkind_d = pkind_q;
    pid_d   = pid_q;
    paddr_d = paddr_q;
    plive_d = plive_q;
    if (link_break)
      last_d = LAST_INVALID;
    else if (xfer_done && plive_q) begin
      if (!xfer_ok || pkind_q == K_TERM)
        last_d = LAST_INVALID;
      else if (pkind_q == K_ACCESS)
        last_d = {pid_q, paddr_q[ADDR_W-1:2], 2'b00};
    end
    if (capture) begin
      plive_d = 1'b1;
      pkind_d = cap_kind;
      pid_d   = cap_id;
      paddr_d = cap_addr;
    end else if (xfer_done) begin
      plive_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= LAST_INVALID;
      pkind_q <= '0;
      pid_q   <= '0;
      paddr_q <= '0;
      plive_q <= 1'b0;
    end else begin
      last_q  <= last_d;
      plive_q <= plive_d;
      if (capture) begin
        pkind_q <= pkind_d;
        pid_q   <= pid_d;
        paddr_q <= paddr_d;
      end
    end
  end

  p_break_inval_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_break |=> (last_q == LAST_INVALID));
  p_fail_inval_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_ok && plive_q) |=> (last_q == LAST_INVALID));
  p_invalid_never_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SAME) |-> !last_q[0]);
endmodule

// File: rtl/frm_packer.sv
module frm_packer
  import frm_pkg::*;
(
  input  logic [1:0]        kind,
  input  addr_mode_e        mode,
  input  logic [ID_W-1:0]   id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REL_W-1:0]  rel_off,
  input  logic [1:0]        size,
  input  logic              write,
  input  logic [8*NBYTES-1:0] wdata,
  output logic [MSG_W-1:0]  msg,
  output logic [MLEN_W-1:0] len
);
  function automatic logic [MSG_W-1:0] put(input logic [MSG_W-1:0] m,
                                           input logic [31:0] v, input int w);
    put = (m << w) | (MSG_W'(v) & ((MSG_W'(1) << w) - MSG_W'(1)));
  endfunction

  always_comb begin
    logic [MSG_W-1:0]  m;
    logic [ADDR_W-1:0] fld;
    int n, aw, nb;
    m = '0;
    n = 0;
    fld = '0;
    aw = ADDR_W;
    nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    m = put(m, 32'(id), ID_W); n += ID_W;
    case (kind)
      K_DPOLL: begin m = put(m, 32'(OP_DPOLL), 3); n += 3; end
      K_EPOLL: begin m = put(m, 32'(OP_EPOLL), 3); n += 3; end
      K_TERM:  begin m = put(m, 32'(OP_TERM), 6);  n += 6; end
      default: begin
        case (mode)
          M_SAME: begin
            m = put(m, 32'(OP_SAME), 2); n += 2;
            fld = ADDR_W'(addr[1:0]); aw = 2;
          end
          M_REL: begin
            m = put(m, 32'(OP_REL), 3); n += 3;
            fld = ADDR_W'(rel_off); aw = REL_W;
          end
          default: begin
            m = put(m, 32'(OP_ABS), 3); n += 3;
            fld = addr; aw = ADDR_W;
          end
        endcase
        if (nb == 2) fld[0] = 1'b0;
        else if (nb == 4) fld[1:0] = 2'b01;
        m = put(m, 32'(!write), 1); n += 1;
        m = put(m, 32'(fld), aw); n += aw;
        m = put(m, 32'(nb > 1), 1); n += 1;
        for (int i = 0; i < NBYTES; i++) begin
          if (write && i < nb) begin
            m = put(m, 32'(wdata[8*i +: 8]), 8);
            n += 8;
          end
        end
      end
    endcase
    msg = m;
    len = MLEN_W'(n);
  end
endmodule

// File: rtl/frm_crc_serial.sv
module frm_crc_serial
  import frm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MSG_W-1:0]  msg_in,
  input  logic [MLEN_W-1:0] len_in,
  output logic              busy,
  output logic [CRC_W-1:0]  crc
);
  logic [MSG_W-1:0]  sreg_q, sreg_d;
  logic [MLEN_W-1:0] cnt_q, cnt_d;
  logic [CRC_W-1:0]  crc_q, crc_d;

  assign busy = (cnt_q != '0);
  assign crc  = crc_q;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    crc_d  = crc_q;
    if (load) begin
      sreg_d = msg_in << (MLEN_W'(MSG_W) - len_in);
      cnt_d  = len_in;
      crc_d  = crc_step('0, 1'b1);   // leading start bit
    end else if (busy) begin
      crc_d  = crc_step(crc_q, sreg_q[MSG_W-1]);
      sreg_d = sreg_q << 1;
      cnt_d  = cnt_q - MLEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      crc_q  <= '0;
    end else if (load || busy) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
    end
  end

  p_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len_in != '0) |=> busy);
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - MLEN_W'(1)));
endmodule

// File: rtl/svc_frame_encoder.sv
module svc_frame_encoder
  import frm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [ID_W-1:0]    req_id,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic               req_write,
  input  logic [8*NBYTES-1:0] req_wdata,
  output logic               frame_valid,
  input  logic               frame_ready,
  output logic [FRAME_W-1:0] frame_data,
  output logic [LEN_W-1:0]   frame_len,
  input  logic               xfer_done,
  input  logic               xfer_ok,
  input  logic               link_break
);
  typedef enum logic [1:0] {S_IDLE, S_CRC, S_OUT} state_e;

  state_e            st_q, st_d;
  logic [MSG_W-1:0]  msg_q, pk_msg;
  logic [MLEN_W-1:0] mlen_q, pk_len;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic [LEN_W-1:0]  flen_q, flen_d;
  logic              accept, crc_busy, finish;
  logic [CRC_W-1:0]  crc_val;
  addr_mode_e        mode;
  logic [REL_W-1:0]  rel_off;

  assign req_ready   = (st_q == S_IDLE);
  assign frame_valid = (st_q == S_OUT);
  assign frame_data  = frm_q;
  assign frame_len   = flen_q;
  assign accept      = req_valid && req_ready;
  assign finish      = (st_q == S_CRC) && !crc_busy;

  frm_last_addr u_last (
    .clk, .rst_n,
    .capture(accept), .cap_kind(req_kind), .cap_id(req_id), .cap_addr(req_addr),
    .xfer_done, .xfer_ok, .link_break,
    .mode, .rel_off
  );

  frm_packer u_pack (
    .kind(req_kind), .mode, .id(req_id), .addr(req_addr), .rel_off,
    .size(req_size), .write(req_write), .wdata(req_wdata),
    .msg(pk_msg), .len(pk_len)
  );

  frm_crc_serial u_crc (
    .clk, .rst_n, .load(accept), .msg_in(pk_msg), .len_in(pk_len),
    .busy(crc_busy), .crc(crc_val)
  );

  always_comb begin
    st_d   = st_q;
    frm_d  = {msg_q, crc_val} << (LEN_W'(MSG_W) - LEN_W'(mlen_q));
    flen_d = LEN_W'(mlen_q) + LEN_W'(CRC_W);
    case (st_q)
      S_IDLE: if (req_valid) st_d = S_CRC;
      S_CRC:  if (!crc_busy) st_d = S_OUT;
      S_OUT:  if (frame_ready) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      msg_q  <= '0;
      mlen_q <= '0;
      frm_q  <= '0;
      flen_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        msg_q  <= pk_msg;
        mlen_q <= pk_len;
      end
      if (finish) begin
        frm_q  <= frm_d;
        flen_q <= flen_d;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_ready) |=> (frame_valid && $stable(frame_data) && $stable(frame_len)));
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_len >= LEN_W'(9) && frame_len <= LEN_W'(FRAME_W)));
  p_left_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ((frame_data << frame_len) == '0));
endmodule

// File: tb/svc_frame_encoder_bench.sv
module svc_frame_encoder_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, frame_valid, frame_ready;
  logic xfer_done, xfer_ok, link_break;
  logic [1:0] req_kind, req_id, req_size;
  logic [20:0] req_addr;
  logic [31:0] req_wdata;
  logic [63:0] frame_data;
  logic [6:0] frame_len;

  always #4 clk = ~clk;   // 125 MHz

  svc_frame_encoder u_svc_frame_encoder (.*);

  int checks = 0, fails = 0, seen = 0;
  bit finished = 0, stall_en = 0;
  logic [63:0] exp_d[$];
  logic [6:0]  exp_l[$];
  string       exp_t[$];
  logic [22:0] m_last;
  logic [7:0]  lfsr = 8'h5a;
  bit hold_pend = 0;
  logic [63:0] hold_d;
  logic [6:0]  hold_l;

  function automatic logic [63:0] pushb(input logic [63:0] m, input logic [31:0] v, input int w);
    return (m << w) | (64'(v) & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic void model(input logic [1:0] kind, input logic [1:0] id, input logic [20:0] addr,
      input logic [1:0] sz, input logic wr, input logic [31:0] wd, input logic [22:0] last,
      output logic [63:0] fr, output logic [6:0] fl);
    logic [63:0] m = 0;
    logic [3:0] c = 0;
    int n = 0, nb, d, aw;
    logic [20:0] f;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    m = pushb(m, id, 2); n += 2;
    if (kind == 1) begin m = pushb(m, 3'b010, 3); n += 3; end
    else if (kind == 2) begin m = pushb(m, 3'b011, 3); n += 3; end
    else if (kind == 3) begin m = pushb(m, 6'b111111, 6); n += 6; end
    else begin
      d = int'(addr) - int'(last[20:0]);
      if (last == {id, addr[20:2], 2'b00}) begin
        m = pushb(m, 2'b11, 2); n += 2; f = 21'(addr[1:0]); aw = 2;
      end else if (last[0] == 0 && last[22:21] == id && d >= -256 && d <= 255) begin
        m = pushb(m, 3'b101, 3); n += 3; f = 21'(d[8:0]); aw = 9;
      end else begin
        m = pushb(m, 3'b100, 3); n += 3; f = addr; aw = 21;
      end
      if (nb == 2) f[0] = 0;
      if (nb == 4) f[1:0] = 2'b01;
      m = pushb(m, wr ? 0 : 1, 1); n += 1;
      m = pushb(m, 32'(f), aw); n += aw;
      m = pushb(m, (nb > 1) ? 1 : 0, 1); n += 1;
      if (wr) for (int i = 0; i < nb; i++) begin m = pushb(m, wd[8*i +: 8], 8); n += 8; end
    end
    begin
      logic fb;
      fb = 1'b1 ^ c[3]; c = {c[2:0], 1'b0} ^ (fb ? 4'h7 : 4'h0);
      for (int i = n - 1; i >= 0; i--) begin
        fb = m[i] ^ c[3]; c = {c[2:0], 1'b0} ^ (fb ? 4'h7 : 4'h0);
      end
    end
    m = pushb(m, c, 4); n += 4;
    fr = m << (64 - n);
    fl = 7'(n);
  endfunction

  // frame_ready throttling behaves as a registered signal
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    frame_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        checks++;
        if (!frame_valid || frame_data !== hold_d || frame_len !== hold_l) begin
          fails++;
          $display("FAIL R11 stalled frame changed: actual=%h/%0d expected=%h/%0d",
                   frame_data, frame_len, hold_d, hold_l);
        end
        hold_pend = 0;
      end
      if (frame_valid && !frame_ready) begin
        hold_pend = 1; hold_d = frame_data; hold_l = frame_len;
      end
      if (frame_valid && frame_ready) begin
        checks++;
        if (exp_d.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected frame: actual=%h expected=none", frame_data);
        end else begin
          logic [63:0] ed; logic [6:0] el; string t;
          ed = exp_d.pop_front(); el = exp_l.pop_front(); t = exp_t.pop_front();
          if (frame_data !== ed || frame_len !== el) begin
            fails++;
            $display("FAIL %s frame: actual=%h/%0d expected=%h/%0d", t, frame_data, frame_len, ed, el);
          end
        end
        seen++;
      end
    end
  end

  task automatic send(input string tag, input logic [1:0] kind, input logic [1:0] id,
                      input logic [20:0] addr, input logic [1:0] sz, input logic wr,
                      input logic [31:0] wd, input bit ok);
    logic [63:0] fr; logic [6:0] fl; int target;
    model(kind, id, addr, sz, wr, wd, m_last, fr, fl);
    exp_d.push_back(fr); exp_l.push_back(fl); exp_t.push_back(tag);
    target = seen + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_kind = kind; req_id = id; req_addr = addr;
    req_size = sz; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (seen < target) @(negedge clk);
    xfer_done = 1; xfer_ok = ok;
    @(negedge clk);
    xfer_done = 0;
    // R10 model of the stored address
    if (!ok || kind == 3) m_last = 23'h1;
    else if (kind == 0) m_last = {id, addr[20:2], 2'b00};
  endtask

  task automatic brk();
    @(negedge clk); link_break = 1;
    @(negedge clk); link_break = 0;
    m_last = 23'h1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_id = 0; req_addr = 0; req_size = 0;
    req_write = 0; req_wdata = 0; xfer_done = 0; xfer_ok = 0; link_break = 0;
    m_last = 23'h1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || frame_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: actual ready=%b valid=%b expected ready=1 valid=0", req_ready, frame_valid);
    end
    send("R1 R2 first absolute read", 0, 1, 21'h01234, 2, 0, 0, 1);
    send("R3 same word read", 0, 1, 21'h01236, 2, 0, 0, 1);
    send("R4 R7 relative write 2B", 0, 1, 21'h01275, 1, 1, 32'h0000_a55a, 1);
    send("R4 offset -256 read, fails", 0, 1, 21'h01174, 0, 0, 0, 0);
    send("R10 after failure absolute", 0, 1, 21'h01174, 0, 0, 0, 1);
    send("R4 offset +255", 0, 1, 21'h01273, 0, 0, 0, 1);
    send("R5 other id absolute", 0, 2, 21'h01270, 0, 0, 0, 1);
    send("R4 offset +256 absolute", 0, 2, 21'h01370, 0, 1, 32'h77, 1);
    send("R4 offset -257 absolute", 0, 2, 21'h0126f, 0, 0, 0, 1);
    send("R9 data poll", 1, 2, 0, 0, 0, 0, 1);
    send("R10 poll keeps same form", 0, 2, 21'h0126c, 0, 0, 0, 1);
    send("R9 error poll, fails", 2, 0, 0, 0, 0, 0, 0);
    send("R10 R6 absolute after failed poll 4B write", 0, 2, 21'h1fffff, 3, 1, 32'hdeadbeef, 1);
    stall_en = 1;
    send("R9 R11 terminate", 3, 3, 0, 0, 0, 0, 1);
    send("R10 after terminate absolute", 0, 2, 21'h1ffffc, 2, 0, 0, 1);
    send("R3 R11 same write 1B", 0, 2, 21'h1ffffd, 0, 1, 32'hc3, 1);
    brk();
    send("R10 after break absolute", 0, 2, 21'h1ffffd, 0, 0, 0, 1);
    for (int k = 0; k < 60; k++) begin
      logic [20:0] a; logic [1:0] kd;
      a = 21'(21'h40000 + ($urandom % 700));
      kd = ($urandom % 6 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      stall_en = (k % 2 == 0);
      send("R2 R6 R8 mixed", kd, 2'($urandom % 2), a, 2'($urandom), 1'($urandom),
           $urandom, ($urandom % 8) != 0);
    end
    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule